// File: doc/BRIEF.md
# Eight-Level Prioritized Interrupt Controller

This block collects eight interrupt request lines that are asynchronous to its clock and turns them into a single interrupt output and an 8-bit vector for a CPU. Each line passes through a two-flop synchronizer. It is then captured in a pending register, either on a rising edge or by following the line's level, as a mode input selects. A mask register gates the pending levels. A fixed-priority resolver then selects the best unmasked request, where line 0 ranks highest and line 7 lowest.

The winning request raises the interrupt output only when it outranks every level already in service. Lower-priority requests therefore wait while a higher-priority routine runs, and higher-priority requests can nest on top of it. When the CPU pulses the acknowledge input, the winning level is moved into the in-service register. While the acknowledge is high, the block drives a vector made of a programmable base (bits 7:3) and the level number (bits 2:0). If nothing is eligible at acknowledge time, the block answers with level 7 as a spurious interrupt and leaves the in-service register unchanged.

Software uses a small synchronous register port to program the mask and the vector base, to issue a non-specific end-of-interrupt, and to read the mask, pending, in-service and base registers.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask, pending, in-service and base registers read 0, `int_out` is 0 and `vec_out` is 0.
- R2: In edge mode (`lvl_mode`=0) a low-to-high change on a request line sets its pending bit. Acknowledging that level clears the pending bit, and a line that stays high afterwards does not set it again.
- R3: In level mode (`lvl_mode`=1) the pending register follows the synchronized request lines, so a bit clears when its line drops.
- R4: A set mask bit keeps its level from raising `int_out` or from being acknowledged. Its pending bit remains readable. Masking a higher level does not block lower levels.
- R5: Priority is fixed: a lower line index outranks a higher index, and the acknowledged level is the lowest-indexed eligible request.
- R6: `int_out` is 1 only when an unmasked pending level has a lower index than the lowest-indexed set in-service bit, or when no in-service bit is set.
- R7: While `ack` is 1, `vec_out` = {base[7:3], level[2:0]}, and `vec_out` is 0 while `ack` is 0. An acknowledge sets the level's in-service bit.
- R8: An acknowledge with no eligible request drives level 7 in `vec_out[2:0]` and leaves the in-service register unchanged.
- R9: A write to address 1 (end-of-interrupt; data ignored) clears only the lowest-indexed set in-service bit.
- R10: A read with `reg_rd`=1 returns on `reg_rdata` at the next clock edge: address 0 mask, 1 pending, 2 in-service, 3 base. A write to address 0 loads the mask.
- R11: A write to address 2 loads the base from `reg_wdata[7:3]`. Base reads return those bits with bits 2:0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous request lines, index 0 highest priority |
| lvl_mode | input | 1 | 1 = level sensing, 0 = edge sensing |
| ack | input | 1 | Interrupt acknowledge from the CPU, one cycle per acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| int_out | output | 1 | Interrupt request to the CPU (registered) |
| vec_out | output | 8 | Vector, valid while `ack` is high |

## Verification
The in-RTL assertions check four things on every cycle. `int_out` never rises without an unmasked pending level. Each real acknowledge adds exactly one in-service bit. Each end-of-interrupt removes exactly one. The vector is zero outside acknowledge and carries level 7 when the acknowledge is spurious. Only the bench scenarios show the rest: which level wins when several lines or masks compete, how nested levels block and then release lower ones, the difference between edge and level capture, and the register read-back values.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_MASK = 2'd0,
    RA_PEND = 2'd1,
    RA_INSV = 2'd2,
    RA_BASE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw_in,
  output logic [N_LINES-1:0] lvl,
  output logic [N_LINES-1:0] rise
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= raw_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl[g]  = sync_q;
    assign rise[g] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned N_BITS = 8,
  localparam int unsigned IDX_W = $clog2(N_BITS)
) (
  input  logic [N_BITS-1:0] vec,
  output logic [N_BITS-1:0] onehot,
  output logic [IDX_W-1:0]  idx,
  output logic              any
);
  always_comb begin
    idx = '0;
    for (int i = N_BITS - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign onehot = vec & (~vec + N_BITS'(1));
  assign any    = |vec;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned N_LVL = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned LVL_W  = $clog2(N_LVL),
  localparam int unsigned BASE_W = VEC_W - LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] irq_in,
  input  logic             lvl_mode,
  input  logic             ack,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [VEC_W-1:0] reg_wdata,
  output logic [VEC_W-1:0] reg_rdata,
  output logic             int_out,
  output logic [VEC_W-1:0] vec_out
);
  import irq_pkg::*;

  logic [N_LVL-1:0]  s_lvl, s_rise;
  logic [N_LVL-1:0]  pend_edge_q, pend_view, mask_q, isr_q;
  logic [N_LVL-1:0]  req, below, eligible;
  logic [N_LVL-1:0]  isr_oh, win_oh, set_oh, clr_oh;
  logic [LVL_W-1:0]  isr_idx, win_idx, ack_lvl;
  logic              isr_any, win_any, take, eoi;
  logic [BASE_W-1:0] base_q;
  logic              int_q;
  logic [VEC_W-1:0]  rdata_q;

  irq_sync_edge #(.N_LINES(N_LVL)) u_sync (
    .clk(clk), .rst(rst), .raw_in(irq_in), .lvl(s_lvl), .rise(s_rise)
  );

  assign pend_view = lvl_mode ? s_lvl : pend_edge_q;
  assign req       = pend_view & ~mask_q;

  irq_lowest_pick #(.N_BITS(N_LVL)) u_isr_pick (
    .vec(isr_q), .onehot(isr_oh), .idx(isr_idx), .any(isr_any)
  );

  // Levels strictly above the lowest in-service bit; all ones when none is in service.
  assign below    = isr_oh - N_LVL'(1);
  assign eligible = req & below;

  irq_lowest_pick #(.N_BITS(N_LVL)) u_win_pick (
    .vec(eligible), .onehot(win_oh), .idx(win_idx), .any(win_any)
  );

  assign ack_lvl = win_any ? win_idx : {LVL_W{1'b1}};
  assign take    = ack & win_any;
  assign set_oh  = take ? win_oh : '0;
  assign eoi     = reg_wr && (reg_addr == RA_PEND);
  assign clr_oh  = eoi ? isr_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_edge_q <= '0;
      isr_q       <= '0;
      mask_q      <= '0;
      base_q      <= '0;
      int_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      // A fresh rising edge takes precedence over an acknowledge clear of the same bit.
      pend_edge_q <= lvl_mode ? '0 : ((pend_edge_q & ~set_oh) | s_rise);
      isr_q       <= (isr_q & ~clr_oh) | set_oh;
      int_q       <= |eligible;
      if (reg_wr && reg_addr == RA_MASK) mask_q <= reg_wdata[N_LVL-1:0];
      if (reg_wr && reg_addr == RA_INSV) base_q <= reg_wdata[VEC_W-1:LVL_W];
      if (reg_rd) begin
        case (reg_addr)
          RA_MASK: rdata_q <= VEC_W'(mask_q);
          RA_PEND: rdata_q <= VEC_W'(pend_view);
          RA_INSV: rdata_q <= VEC_W'(isr_q);
          default: rdata_q <= {base_q, {LVL_W{1'b0}}};
        endcase
      end
    end
  end

  assign int_out   = int_q;
  assign reg_rdata = rdata_q;
  assign vec_out   = ack ? {base_q, ack_lvl} : '0;

  // R4/R6: the interrupt never rises without an unmasked pending level behind it.
  a_r6_int_has_source: assert property (@(posedge clk) disable iff (rst)
    $rose(int_out) |-> $past(|(pend_view & ~mask_q)));

  // R7: a real acknowledge adds exactly one in-service bit.
  a_r7_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
    (ack && |(pend_view & ~mask_q & below) && !eoi) |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  // R9: end-of-interrupt removes exactly one in-service bit.
  a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && isr_q != '0) |=> $countones(isr_q) + 1 == $past($countones(isr_q)));

  // R8: a spurious acknowledge answers with the last level and leaves service state alone.
  a_r8_spurious_lvl: assert property (@(posedge clk) disable iff (rst)
    (ack && (pend_view & ~mask_q & below) == '0) |-> vec_out[LVL_W-1:0] == {LVL_W{1'b1}});

  a_r8_spurious_keep: assert property (@(posedge clk) disable iff (rst)
    (ack && (pend_view & ~mask_q & below) == '0 && !eoi) |=> $stable(isr_q));

  // R7: no vector outside acknowledge.
  a_r7_vec_idle: assert property (@(posedge clk) disable iff (rst)
    !ack |-> vec_out == '0);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       lvl_mode = 1'b0;
  logic       ack = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       int_out;
  logic [7:0] vec_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_mode(lvl_mode), .ack(ack),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_out(int_out), .vec_out(vec_out)
  );

  // Fields: [20] level mode, [19:12] lines, [11:4] mask, [3] interrupt expected, [2:0] level.
  localparam logic [20:0] TBL [8] = '{
    {1'b0, 8'h01, 8'h00, 1'b1, 3'd0},
    {1'b0, 8'h80, 8'h00, 1'b1, 3'd7},
    {1'b0, 8'h24, 8'h00, 1'b1, 3'd2},
    {1'b0, 8'h24, 8'h04, 1'b1, 3'd5},
    {1'b0, 8'h10, 8'h10, 1'b0, 3'd7},
    {1'b1, 8'h48, 8'h00, 1'b1, 3'd3},
    {1'b1, 8'hC0, 8'h40, 1'b1, 3'd7},
    {1'b1, 8'h00, 8'h00, 1'b0, 3'd7}
  };
  localparam logic [4:0] BASE_HI = 5'b10101;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    ack = 1'b1;
    #1 v = vec_out;
    @(posedge clk);
    #1 ack = 1'b0;
  endtask

  task automatic flush();
    lvl_mode = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 int_out", {7'b0, int_out}, 8'h00);
    check("R1 vec_out", vec_out, 8'h00);
    rd(2'd0, d); check("R1 mask", d, 8'h00);
    rd(2'd1, d); check("R1 pending", d, 8'h00);
    rd(2'd2, d); check("R1 in-service", d, 8'h00);
    rd(2'd3, d); check("R1 base", d, 8'h00);

    // R11 base programming
    wr(2'd2, 8'hFF);
    rd(2'd3, d); check("R11 base low bits dropped", d, 8'hF8);
    wr(2'd2, {BASE_HI, 3'b011});
    rd(2'd3, d); check("R11 base", d, {BASE_HI, 3'b000});
    // R10 mask read-back
    wr(2'd0, 8'h5A);
    rd(2'd0, d); check("R10 mask", d, 8'h5A);
    wr(2'd0, 8'h00);

    // Table: R4 R5 R7 R8 over edge and level modes
    foreach (TBL[i]) begin
      flush();
      lvl_mode = TBL[i][20];
      wr(2'd0, TBL[i][11:4]);
      irq_in = TBL[i][19:12];
      tick(6);
      check($sformatf("R5/R6 row %0d int_out", i), {7'b0, int_out}, {7'b0, TBL[i][3]});
      do_ack(v);
      check($sformatf("R7/R8 row %0d vector", i), v, {BASE_HI, TBL[i][2:0]});
      rd(2'd2, d);
      check($sformatf("R7/R8 row %0d in-service", i), d,
            TBL[i][3] ? (8'h01 << TBL[i][2:0]) : 8'h00);
      if (TBL[i][3]) wr(2'd1, 8'h00);
      if (TBL[i][11:4] != 8'h00 && !TBL[i][20]) begin
        rd(2'd1, d);
        check($sformatf("R4 row %0d masked still pending", i), d & TBL[i][11:4], TBL[i][11:4] & TBL[i][19:12]);
      end
      irq_in = '0;
      wr(2'd0, 8'h00);
      tick(4);
    end

    // Nesting in edge mode: R2 R6 R9
    flush();
    lvl_mode = 1'b0;
    tick(2);
    irq_in = 8'h08;
    tick(6);
    do_ack(v); check("R7 nest ack level 3", v, {BASE_HI, 3'd3});
    rd(2'd1, d); check("R2 pending cleared by ack", d, 8'h00);
    irq_in = 8'h28;
    tick(6);
    check("R6 lower level blocked", {7'b0, int_out}, 8'h00);
    rd(2'd1, d); check("R2 edge latched", d, 8'h20);
    irq_in = 8'h2A;
    tick(6);
    check("R6 higher level nests", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R5 nest ack level 1", v, {BASE_HI, 3'd1});
    rd(2'd2, d); check("R7 nested in-service", d, 8'h0A);
    wr(2'd1, 8'hFF);
    rd(2'd2, d); check("R9 eoi clears lowest", d, 8'h08);
    tick(4);
    check("R6 still blocked by level 3", {7'b0, int_out}, 8'h00);
    wr(2'd1, 8'h00);
    tick(4);
    check("R6 released after eoi", {7'b0, int_out}, 8'h01);
    do_ack(v); check("R5 ack level 5", v, {BASE_HI, 3'd5});
    wr(2'd1, 8'h00);
    tick(4);
    rd(2'd1, d); check("R2 held lines not relatched", d, 8'h00);
    check("R2 no interrupt from held lines", {7'b0, int_out}, 8'h00);
    check("R7 vector idle", vec_out, 8'h00);
    irq_in = '0;

    // R3 level follows line
    lvl_mode = 1'b1;
    irq_in = 8'h02;
    tick(6);
    rd(2'd1, d); check("R3 level pending", d, 8'h02);
    irq_in = 8'h00;
    tick(4);
    rd(2'd1, d); check("R3 level drops", d, 8'h00);
    check("R3 no interrupt", {7'b0, int_out}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule